// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the control and status state for one channel of a simple bus-master DMA engine that feeds a disk-style or network peripheral. A host reaches four 32-bit words through a single-cycle, word-wide register port: a control/status word, a transfer address, a byte count and a word of upper address bits. Reads are combinational from the stored state and have no side effects. Writes take effect at the next rising clock edge.

The block sits between the host and the peripheral. It latches the peripheral's interrupt into a pending flag and gates that flag with a software enable to drive the host interrupt. It gives the peripheral a one-cycle reset pulse and a DMA-enable level. It also has a transfer-advance port, so the external bus master can move the address forward by the number of bytes it has just moved. The network-side address is the transfer address ORed with the upper-address word. A parameter selects whether that OR is applied.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word reads 0xA0000000 and the address, count and upper-address words read 0.
- R2: `reg_addr[3:2]` selects the word: 0 is control/status, 1 is address, 2 is count and 3 is upper address. The count and upper-address words read back exactly what was last written.
- R3: A write to control/status keeps the old value of every bit in mask 0xFE000007 and takes the written data in all other bits, except bits 6 and 7.
- R4: Bits 6 (drain) and 7 (peripheral reset) always read 0. Writing 1 to bit 7 drives `periph_rst_pulse` high for exactly the one cycle after the write edge.
- R5: A write to the address word sets bit 26 (address loaded) of control/status. That bit stays set until reset.
- R6: `dma_en_out` follows control/status bit 9 from the write edge onward, and `xfer_to_mem` follows bit 8 (1 = write to memory).
- R7: A rising level on `periph_irq_in` sets the pending flag in bit 0 of control/status. A falling level clears it. Host writes never change bit 0.
- R8: `host_irq_out` is high exactly when bit 0 and the interrupt enable in bit 4 are both set. Clearing bit 4 drops the output on the write edge while bit 0 stays set. Setting bit 4 while bit 0 is set raises the output on that edge.
- R9: A cycle with `xfer_done` high adds `xfer_bytes` to the address word. A host write to the address word in the same cycle takes priority over the advance.
- R10: `eth_xfer_addr` equals the address word ORed with the upper-address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select (address bits 3:2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| periph_irq_in | input | 1 | Interrupt level from the peripheral |
| host_irq_out | output | 1 | Interrupt to the host |
| periph_rst_pulse | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_out | output | 1 | DMA enable level to the peripheral |
| xfer_to_mem | output | 1 | Direction: 1 = peripheral to memory |
| xfer_done | input | 1 | A transfer of `xfer_bytes` bytes has completed |
| xfer_bytes | input | CNT_W | Number of bytes just moved |
| eth_xfer_addr | output | 32 | Address with upper bits merged |

## Verification
A table of writes and readbacks first probes the reset image, then plain storage in the count and upper words, then all-ones and all-zeros writes to control/status. Those two writes show the read-only lanes apart from the writable lanes and from the self-clearing command bits. Directed sequences then check the interrupt path in every order of input edge and enable change, so a design that latches the output itself can be told from one that gates the pending flag live. Address advances use two different byte counts and one collision with a host write, which tells apart a correct adder, a fixed increment and the wrong priority.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      SEL_CSR  = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_HI   = 2'd3
   } reg_sel_e;

   localparam int B_PEND  = 0;
   localparam int B_IEN   = 4;
   localparam int B_DRAIN = 6;
   localparam int B_PRST  = 7;
   localparam int B_DIR   = 8;
   localparam int B_DEN   = 9;
   localparam int B_LOAD  = 26;

   // Merge a host write into the status word: protected lanes keep the old value,
   // command bits never stick.
   function automatic logic [WORD_W-1:0] csr_merge(input logic [WORD_W-1:0] old_v,
                                                  input logic [WORD_W-1:0] wr_v,
                                                  input logic [WORD_W-1:0] ro_m);
      logic [WORD_W-1:0] m;
      m = (old_v & ro_m) | (wr_v & ~ro_m);
      m[B_DRAIN] = 1'b0;
      m[B_PRST]  = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/dma_word_reg.sv
module dma_word_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (wr_i) q_o <= wdata_i;
   end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int W     = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [W-1:0]     wdata_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] bytes_i,
   output logic [W-1:0]     addr_o
);
   localparam int PAD_W = W - CNT_W;

   logic [W-1:0] step;

   generate
      if (PAD_W > 0) begin : g_pad
         assign step = {{PAD_W{1'b0}}, bytes_i};
      end else begin : g_nopad
         assign step = bytes_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_o <= '0;
      else if (wr_i)    addr_o <= wdata_i;
      else if (adv_i)   addr_o <= addr_o + step;
   end
endmodule

// File: rtl/dma_csr.sv
module dma_csr
   import dma_regs_pkg::*;
#(
   parameter logic [WORD_W-1:0] VERSION = 32'hA000_0000,
   parameter logic [WORD_W-1:0] RO_MASK = 32'hFE00_0007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              addr_wr_i,
   input  logic              irq_in_i,
   output logic [WORD_W-1:0] csr_o,
   output logic              rst_pulse_o
);
   logic              irq_prev_q;
   logic              irq_rise;
   logic              irq_fall;
   logic [WORD_W-1:0] csr_d;

   assign irq_rise = irq_in_i & ~irq_prev_q;
   assign irq_fall = ~irq_in_i & irq_prev_q;

   always_comb begin
      csr_d = wr_i ? csr_merge(csr_o, wdata_i, RO_MASK) : csr_o;
      if (addr_wr_i) csr_d[B_LOAD] = 1'b1;
      if (irq_rise)      csr_d[B_PEND] = 1'b1;
      else if (irq_fall) csr_d[B_PEND] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_o       <= VERSION;
         irq_prev_q  <= 1'b0;
         rst_pulse_o <= 1'b0;
      end else begin
         csr_o       <= csr_d;
         irq_prev_q  <= irq_in_i;
         rst_pulse_o <= wr_i & wdata_i[B_PRST];
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int                CNT_W     = 16,
   parameter bit                ETH_HI_EN = 1'b1,
   parameter logic [WORD_W-1:0] VERSION   = 32'hA000_0000,
   parameter logic [WORD_W-1:0] RO_MASK   = 32'hFE00_0007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:2]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              periph_irq_in,
   output logic              host_irq_out,
   output logic              periph_rst_pulse,
   output logic              dma_en_out,
   output logic              xfer_to_mem,
   input  logic              xfer_done,
   input  logic [CNT_W-1:0]  xfer_bytes,
   output logic [31:0]       eth_xfer_addr
);
   generate
      if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
         $error("dma_chan_regs: CNT_W must be 1..32");
      end
      if ((RO_MASK & 32'h0000_03D0) != 0) begin : g_bad_mask
         $error("dma_chan_regs: RO_MASK covers a control bit");
      end
      if (RO_MASK[B_PEND] == 1'b0 || RO_MASK[B_LOAD] == 1'b0) begin : g_bad_ro
         $error("dma_chan_regs: status bits must be read-only");
      end
   endgenerate

   reg_sel_e          sel;
   logic              wr_csr, wr_addr, wr_cnt, wr_hi;
   logic [WORD_W-1:0] csr_q, addr_q, cnt_q, hi_q;

   assign sel     = reg_sel_e'(reg_addr);
   assign wr_csr  = reg_we && (sel == SEL_CSR);
   assign wr_addr = reg_we && (sel == SEL_ADDR);
   assign wr_cnt  = reg_we && (sel == SEL_CNT);
   assign wr_hi   = reg_we && (sel == SEL_HI);

   dma_csr #(.VERSION(VERSION), .RO_MASK(RO_MASK)) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (wr_csr),
      .wdata_i     (reg_wdata),
      .addr_wr_i   (wr_addr),
      .irq_in_i    (periph_irq_in),
      .csr_o       (csr_q),
      .rst_pulse_o (periph_rst_pulse)
   );

   dma_addr_ctr #(.W(WORD_W), .CNT_W(CNT_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_addr),
      .wdata_i (reg_wdata),
      .adv_i   (xfer_done),
      .bytes_i (xfer_bytes),
      .addr_o  (addr_q)
   );

   dma_word_reg #(.W(WORD_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_cnt),
      .wdata_i (reg_wdata),
      .q_o     (cnt_q)
   );

   dma_word_reg #(.W(WORD_W)) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_hi),
      .wdata_i (reg_wdata),
      .q_o     (hi_q)
   );

   always_comb begin
      unique case (sel)
         SEL_CSR:  reg_rdata = csr_q;
         SEL_ADDR: reg_rdata = addr_q;
         SEL_CNT:  reg_rdata = cnt_q;
         default:  reg_rdata = hi_q;
      endcase
   end

   assign host_irq_out = csr_q[B_PEND] & csr_q[B_IEN];
   assign dma_en_out   = csr_q[B_DEN];
   assign xfer_to_mem  = csr_q[B_DIR];

   generate
      if (ETH_HI_EN) begin : g_hi_merge
         assign eth_xfer_addr = addr_q | hi_q;
      end else begin : g_hi_off
         assign eth_xfer_addr = addr_q;
      end
   endgenerate
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int          CNT_W   = 16,
   parameter logic [31:0] RO_MASK = 32'hFE00_0007
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [3:2]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic             periph_irq_in,
   input logic             host_irq_out,
   input logic             periph_rst_pulse,
   input logic             xfer_done,
   input logic [CNT_W-1:0] xfer_bytes,
   input logic [31:0]      csr_q,
   input logic [31:0]      addr_q
);
   localparam logic [31:0] FIXED_M = RO_MASK & ~32'h0400_0001;

   // R3
   ro_lanes_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(csr_q & FIXED_M));

   // R4
   rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst_pulse |-> $past(reg_we && reg_addr == 2'd0 && reg_wdata[7]));

   // R5
   loaded_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd1) |=> csr_q[26]);

   // R7
   pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_irq_in && !$past(periph_irq_in)) |=> csr_q[0]);

   // R8
   irq_mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && !reg_wdata[4]) |=> !host_irq_out);

   // R9
   addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !(reg_we && reg_addr == 2'd1))
      |=> addr_q == $past(addr_q) + 32'($past(xfer_bytes)));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.CNT_W(CNT_W), .RO_MASK(RO_MASK)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .reg_we           (reg_we),
   .reg_addr         (reg_addr),
   .reg_wdata        (reg_wdata),
   .periph_irq_in    (periph_irq_in),
   .host_irq_out     (host_irq_out),
   .periph_rst_pulse (periph_rst_pulse),
   .xfer_done        (xfer_done),
   .xfer_bytes       (xfer_bytes),
   .csr_q            (csr_q),
   .addr_q           (addr_q)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int NVEC       = 15;

   // {is_write, word, data-or-expected}
   localparam logic [34:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 32'hA000_0000},
      {1'b0, 2'd1, 32'h0000_0000},
      {1'b0, 2'd2, 32'h0000_0000},
      {1'b0, 2'd3, 32'h0000_0000},
      {1'b1, 2'd2, 32'h0000_1234},
      {1'b0, 2'd2, 32'h0000_1234},
      {1'b1, 2'd3, 32'hFF00_0000},
      {1'b0, 2'd3, 32'hFF00_0000},
      {1'b1, 2'd0, 32'hFFFF_FFFF},
      {1'b0, 2'd0, 32'hA1FF_FF38},
      {1'b1, 2'd0, 32'h0000_0000},
      {1'b0, 2'd0, 32'hA000_0000},
      {1'b1, 2'd1, 32'h1000_0040},
      {1'b0, 2'd1, 32'h1000_0040},
      {1'b0, 2'd0, 32'hA400_0000}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_we = 1'b0;
   logic [3:2]       reg_addr = 2'd0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic             periph_irq_in = 1'b0;
   logic             host_irq_out;
   logic             periph_rst_pulse;
   logic             dma_en_out;
   logic             xfer_to_mem;
   logic             xfer_done = 1'b0;
   logic [CNT_W-1:0] xfer_bytes = '0;
   logic [31:0]      eth_xfer_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_regs #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_irq_in(periph_irq_in),
      .host_irq_out(host_irq_out), .periph_rst_pulse(periph_rst_pulse),
      .dma_en_out(dma_en_out), .xfer_to_mem(xfer_to_mem), .xfer_done(xfer_done),
      .xfer_bytes(xfer_bytes), .eth_xfer_addr(eth_xfer_addr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] w, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = w; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [1:0] w, input logic [31:0] exp);
      reg_addr = w;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq out", 32'(host_irq_out), 32'h0);
      check("R1 dma en", 32'(dma_en_out), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = (i < 4) ? "R1 reset word" : (i < 8) ? "R2 plain word" :
               (i < 12) ? "R3 csr merge" : "R5 addr load";
         if (VEC[i][34]) wr(VEC[i][33:32], VEC[i][31:0]);
         else            rd(tag, VEC[i][33:32], VEC[i][31:0]);
      end

      // R6 enable and direction follow bits 9 and 8
      wr(2'd0, 32'h0000_0200);
      check("R6 dma_en high", 32'(dma_en_out), 32'h1);
      check("R6 dir low", 32'(xfer_to_mem), 32'h0);
      wr(2'd0, 32'h0000_0100);
      check("R6 dma_en low", 32'(dma_en_out), 32'h0);
      check("R6 dir high", 32'(xfer_to_mem), 32'h1);

      // R4 reset pulse for one cycle, command bits never stick
      wr(2'd0, 32'h0000_0080);
      check("R4 pulse on", 32'(periph_rst_pulse), 32'h1);
      @(negedge clk);
      check("R4 pulse off", 32'(periph_rst_pulse), 32'h0);
      wr(2'd0, 32'h0000_0040);
      check("R4 pulse none on drain", 32'(periph_rst_pulse), 32'h0);
      rd("R4 bits 7:6 clear", 2'd0, 32'hA400_0000);

      // R7 pending with enable off, host irq stays low
      @(negedge clk); periph_irq_in = 1'b1;
      @(negedge clk);
      rd("R7 pending set", 2'd0, 32'hA400_0001);
      check("R8 masked", 32'(host_irq_out), 32'h0);
      wr(2'd0, 32'h0000_0010);
      check("R8 enable while pending", 32'(host_irq_out), 32'h1);
      wr(2'd0, 32'h0000_0001);
      check("R8 disable lowers", 32'(host_irq_out), 32'h0);
      rd("R7 pending kept, write ignored on bit0", 2'd0, 32'hA400_0001);
      wr(2'd0, 32'h0000_0010);
      check("R8 re-enable", 32'(host_irq_out), 32'h1);
      @(negedge clk); periph_irq_in = 1'b0;
      @(negedge clk);
      check("R7 fall drops irq", 32'(host_irq_out), 32'h0);
      rd("R7 pending cleared", 2'd0, 32'hA400_0010);
      @(negedge clk); periph_irq_in = 1'b1;
      @(negedge clk);
      check("R8 rise with enable", 32'(host_irq_out), 32'h1);
      @(negedge clk); periph_irq_in = 1'b0;
      wr(2'd0, 32'h0000_0000);

      // R9 address advance
      @(negedge clk); xfer_done = 1'b1; xfer_bytes = 16'd16;
      @(negedge clk); xfer_bytes = 16'd4;
      @(negedge clk); xfer_done = 1'b0;
      rd("R9 advance", 2'd1, 32'h1000_0054);
      // R10 merged address
      check("R10 eth addr", eth_xfer_addr, 32'hFF00_0054);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_2000;
      xfer_done = 1'b1; xfer_bytes = 16'd8;
      @(negedge clk);
      reg_we = 1'b0; xfer_done = 1'b0;
      rd("R9 write wins", 2'd1, 32'h0000_2000);
      check("R10 eth addr 2", eth_xfer_addr, 32'hFF00_2000);
      wr(2'd3, 32'h0000_0000);
      check("R10 eth addr no hi", eth_xfer_addr, 32'h0000_2000);

      // R1 reset again restores the image
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd("R1 csr after reset", 2'd0, 32'hA000_0000);
      rd("R1 addr after reset", 2'd1, 32'h0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule